// File: doc/BRIEF.md
# DSP Register-Move Datapath Unit

This block is the register file of a 16-bit DSP together with the executor for its register-to-register move group. It holds the following state:

- an all-ones constant register;
- two multiplier operand registers, X and Y;
- a 32-bit accumulator;
- a status word;
- a descending hardware return stack;
- the program counter;
- a 32-bit product register.

The accumulator's low half is also reachable under a separate register index.

The unit accepts one 16-bit opcode per transfer on a valid/ready input. An opcode whose top seven bits are zero is a move: bits 3:0 pick the source index and bits 7:4 pick the destination index. The all-zero opcode is a nop. Any other opcode is consumed without effect and flagged on a one-cycle anomaly output.

Back-pressure rule: `op_ready` is low for exactly one cycle after a move that writes the program counter, because a redirect costs an extra cycle. An opcode is taken only on a cycle where `op_valid` and `op_ready` are both high. While `op_ready` is low, the producer holds `op_valid` and `op_data`. When nothing is taken, all state holds. Register contents are brought out on plain observation pins for the surrounding pipeline.

Top module: `dsp_move_unit`

## Requirements
- R1: After reset: PC is 0x0400, stack level is 6, X, Y, status, accumulator and product are zero, `anomaly` is 0 and `op_ready` is 1.
- R2: An opcode is a move when bits 15:9 are zero; source index is bits 3:0, destination index is bits 7:4. Any other accepted opcode sets `anomaly` for the next cycle only, changes no register and advances PC by one.
- R3: Opcode 0x0000 changes nothing but PC, which advances by one.
- R4: Index 0 reads 0xFFFF and writes to it are discarded.
- R5: Reading index 7 refreshes the product register to 2·X·Y mod 2^32 (using X and Y before the move) and returns its upper 16 bits. Writes to index 7 are discarded.
- R6: Opcode 0x0037 refreshes the product and copies all 32 bits into the accumulator.
- R7: Index 3 reads the accumulator's upper 16 bits; a write there replaces the upper half and keeps the lower half. Index 15 reads and writes the lower 16 bits only.
- R8: Index 5 is a 6-deep stack. A write first decrements the level, then stores. A read first fetches the entry at the current level, then increments the level.
- R9: A stack write at level 0, or a stack read at level 6 or above, sets `anomaly` and leaves the level unchanged; such a read returns 0.
- R10: Index 6 reads the address of the executing move. Writing it loads PC with the moved value and drops `op_ready` for exactly one cycle. Every other accepted opcode advances PC by one (16-bit wrap).
- R11: Indices 8 through 14 read as 0 and ignore writes.
- R12: On a cycle where no opcode is accepted, no register, PC or stack level changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode present |
| op_ready | output | 1 | Unit can take an opcode this cycle |
| op_data | input | 16 | Opcode |
| anomaly | output | 1 | One-cycle flag: unhandled opcode or stack fault |
| x_q | output | 16 | X register |
| y_q | output | 16 | Y register |
| acc_q | output | 32 | Accumulator |
| st_q | output | 16 | Status register |
| pc_q | output | 16 | Program counter |
| prod_q | output | 32 | Product register |
| stk_lvl | output | 3 | Stack level (6 = empty, 0 = full) |

## Verification
Every piece of state is registered and visible on a port one edge after the opcode that touches it. A wrong decode or read mux therefore shows up at once as an unexpected value on `x_q`, `y_q`, `acc_q` or `st_q`. Stack corruption stays hidden until the entry is popped back into a visible register, so push/pop sequences are checked in LIFO order, including both fault edges. A stale product shows only when the product is next read. For that reason, X and Y are changed between product reads.

// File: rtl/dsp_mv_pkg.sv
package dsp_mv_pkg;
  localparam int MV_W = 16;
  localparam logic [3:0] RI_ONES = 4'd0;
  localparam logic [3:0] RI_X    = 4'd1;
  localparam logic [3:0] RI_Y    = 4'd2;
  localparam logic [3:0] RI_ACC  = 4'd3;
  localparam logic [3:0] RI_STAT = 4'd4;
  localparam logic [3:0] RI_STK  = 4'd5;
  localparam logic [3:0] RI_PC   = 4'd6;
  localparam logic [3:0] RI_PROD = 4'd7;
  localparam logic [3:0] RI_ALO  = 4'd15;
  localparam logic [MV_W-1:0] PC_AT_RESET = 16'h0400;

  typedef struct packed {
    logic       is_move;
    logic       is_nop;
    logic       is_accp;
    logic [3:0] src;
    logic [3:0] dst;
  } mv_dec_t;
endpackage

// File: rtl/mv_decode.sv
module mv_decode
  import dsp_mv_pkg::*;
(
  input  logic [MV_W-1:0] op,
  output mv_dec_t         dec
);
  always_comb begin
    dec.is_move = (op[15:9] == 7'd0);
    dec.is_nop  = (op == '0);
    dec.src     = op[3:0];
    dec.dst     = op[7:4];
    dec.is_accp = dec.is_move && (op[7:4] == RI_ACC) && (op[3:0] == RI_PROD);
  end
endmodule

// File: rtl/mv_product.sv
module mv_product #(
  parameter int W = 16,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [PW-1:0] prod
);
  logic [PW-1:0] full;
  always_comb begin
    full = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    prod = {full[PW-2:0], 1'b0};
  end
endmodule

// File: rtl/mv_stack.sv
module mv_stack #(
  parameter int W = 16,
  parameter int DEPTH = 6,
  localparam int IW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [IW-1:0] lvl,
  output logic          err
);
  localparam logic [IW-1:0] EMPTY = IW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic          pop_ok, push_ok;
  logic [IW-1:0] lvl_a, lvl_n;

  always_comb begin
    pop_ok  = pop && (lvl < EMPTY);
    rdata   = pop_ok ? mem[lvl] : '0;
    lvl_a   = lvl + IW'(pop_ok);
    push_ok = push && (lvl_a != '0);
    lvl_n   = lvl_a - IW'(push_ok);
    err     = (pop && !pop_ok) || (push && !push_ok);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lvl <= EMPTY;
    else        lvl <= lvl_n;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[lvl_n] <= wdata;
  end

  AST_STK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= EMPTY); // R8
  AST_OVF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && lvl == '0) |=> (lvl == '0)); // R9
  AST_UDF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && lvl == EMPTY) |=> (lvl == EMPTY)); // R9
endmodule

// File: rtl/dsp_move_unit.sv
module dsp_move_unit
  import dsp_mv_pkg::*;
#(
  parameter int STK_DEPTH = 6,
  localparam int STK_IW = $clog2(STK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [15:0]       op_data,
  output logic              anomaly,
  output logic [15:0]       x_q,
  output logic [15:0]       y_q,
  output logic [31:0]       acc_q,
  output logic [15:0]       st_q,
  output logic [15:0]       pc_q,
  output logic [31:0]       prod_q,
  output logic [STK_IW-1:0] stk_lvl
);
  localparam int AW = 2 * MV_W;

  mv_dec_t         dec;
  logic            fire, stall_q, act;
  logic [MV_W-1:0] rd, stk_rdata;
  logic [AW-1:0]   prod_now;
  logic            stk_pop, stk_push, stk_err, pc_wr, p_rd;

  mv_decode u_dec (.op(op_data), .dec(dec));
  mv_product #(.W(MV_W)) u_mul (.a(x_q), .b(y_q), .prod(prod_now));

  assign op_ready = !stall_q;
  assign fire     = op_valid && op_ready;
  assign act      = fire && dec.is_move && !dec.is_nop;
  assign stk_pop  = act && (dec.src == RI_STK);
  assign stk_push = act && (dec.dst == RI_STK);
  assign pc_wr    = act && (dec.dst == RI_PC);
  assign p_rd     = act && (dec.src == RI_PROD);

  mv_stack #(.W(MV_W), .DEPTH(STK_DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .pop(stk_pop), .push(stk_push),
    .wdata(rd), .rdata(stk_rdata), .lvl(stk_lvl), .err(stk_err)
  );

  always_comb begin
    case (dec.src)
      RI_ONES: rd = '1;
      RI_X:    rd = x_q;
      RI_Y:    rd = y_q;
      RI_ACC:  rd = acc_q[AW-1:MV_W];
      RI_STAT: rd = st_q;
      RI_STK:  rd = stk_rdata;
      RI_PC:   rd = pc_q;
      RI_PROD: rd = prod_now[AW-1:MV_W];
      RI_ALO:  rd = acc_q[MV_W-1:0];
      default: rd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0; y_q <= '0; st_q <= '0; acc_q <= '0; prod_q <= '0;
    end else if (act) begin
      if (dec.dst == RI_X)    x_q  <= rd;
      if (dec.dst == RI_Y)    y_q  <= rd;
      if (dec.dst == RI_STAT) st_q <= rd;
      if (p_rd)               prod_q <= prod_now;
      if (dec.is_accp)                acc_q <= prod_now;
      else if (dec.dst == RI_ACC)     acc_q[AW-1:MV_W] <= rd;
      else if (dec.dst == RI_ALO)     acc_q[MV_W-1:0]  <= rd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= PC_AT_RESET; stall_q <= 1'b0; anomaly <= 1'b0;
    end else begin
      anomaly <= fire && (!dec.is_move || stk_err);
      stall_q <= pc_wr;
      if (pc_wr)     pc_q <= rd;
      else if (fire) pc_q <= pc_q + 16'd1;
    end
  end

  AST_STALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ready |=> op_ready); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(pc_q) && $stable(acc_q) && $stable(x_q) && $stable(stk_lvl))); // R12
  AST_UNHANDLED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !dec.is_move) |=> (anomaly && $stable(x_q) && $stable(acc_q))); // R2
  AST_ACCP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dec.is_accp) |=> (acc_q == prod_q)); // R6
  AST_ALO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (act && dec.dst == RI_ACC && !dec.is_accp) |=> (acc_q[15:0] == $past(acc_q[15:0]))); // R7
endmodule

// File: tb/sim_dsp_move_unit.sv
module sim_dsp_move_unit;
  logic        clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
  logic [15:0] op_data = '0;
  logic        op_ready, anomaly;
  logic [15:0] x_q, y_q, st_q, pc_q;
  logic [31:0] acc_q, prod_q;
  logic [2:0]  stk_lvl;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  dsp_move_unit u0 (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_data(op_data), .anomaly(anomaly), .x_q(x_q), .y_q(y_q), .acc_q(acc_q),
    .st_q(st_q), .pc_q(pc_q), .prod_q(prod_q), .stk_lvl(stk_lvl));

  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] op;
    logic [15:0] x, y;
    logic [31:0] acc;
    logic [15:0] pc;
    logic [31:0] p;
    logic [15:0] st;
    logic [2:0]  lvl;
    logic        an;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{4'd3,  16'h0000, 16'h0000, 16'h0000, 32'h00000000, 16'h0401, 32'h00000000, 16'h0000, 3'd6, 1'b0}, // R3 nop
    '{4'd10, 16'h0016, 16'h0401, 16'h0000, 32'h00000000, 16'h0402, 32'h00000000, 16'h0000, 3'd6, 1'b0}, // R10 ld X,PC
    '{4'd4,  16'h0020, 16'h0401, 16'hFFFF, 32'h00000000, 16'h0403, 32'h00000000, 16'h0000, 3'd6, 1'b0}, // R4 ld Y,ones
    '{4'd6,  16'h0037, 16'h0401, 16'hFFFF, 32'h0801F7FE, 16'h0404, 32'h0801F7FE, 16'h0000, 3'd6, 1'b0}, // R6 A<-P
    '{4'd5,  16'h0017, 16'h0801, 16'hFFFF, 32'h0801F7FE, 16'h0405, 32'h0801F7FE, 16'h0000, 3'd6, 1'b0}, // R5 ld X,P
    '{4'd7,  16'h00F3, 16'h0801, 16'hFFFF, 32'h08010801, 16'h0406, 32'h0801F7FE, 16'h0000, 3'd6, 1'b0}, // R7 ld AL,A
    '{4'd7,  16'h0030, 16'h0801, 16'hFFFF, 32'hFFFF0801, 16'h0407, 32'h0801F7FE, 16'h0000, 3'd6, 1'b0}, // R7 ld A,ones
    '{4'd4,  16'h0001, 16'h0801, 16'hFFFF, 32'hFFFF0801, 16'h0408, 32'h0801F7FE, 16'h0000, 3'd6, 1'b0}, // R4 ld ones,X
    '{4'd8,  16'h0051, 16'h0801, 16'hFFFF, 32'hFFFF0801, 16'h0409, 32'h0801F7FE, 16'h0000, 3'd5, 1'b0}, // R8 push X
    '{4'd8,  16'h0052, 16'h0801, 16'hFFFF, 32'hFFFF0801, 16'h040A, 32'h0801F7FE, 16'h0000, 3'd4, 1'b0}, // R8 push Y
    '{4'd8,  16'h0015, 16'hFFFF, 16'hFFFF, 32'hFFFF0801, 16'h040B, 32'h0801F7FE, 16'h0000, 3'd5, 1'b0}, // R8 pop X
    '{4'd8,  16'h0025, 16'hFFFF, 16'h0801, 32'hFFFF0801, 16'h040C, 32'h0801F7FE, 16'h0000, 3'd6, 1'b0}, // R8 pop Y
    '{4'd9,  16'h0015, 16'h0000, 16'h0801, 32'hFFFF0801, 16'h040D, 32'h0801F7FE, 16'h0000, 3'd6, 1'b1}, // R9 underflow
    '{4'd11, 16'h0081, 16'h0000, 16'h0801, 32'hFFFF0801, 16'h040E, 32'h0801F7FE, 16'h0000, 3'd6, 1'b0}, // R11 write idx8
    '{4'd11, 16'h0028, 16'h0000, 16'h0000, 32'hFFFF0801, 16'h040F, 32'h0801F7FE, 16'h0000, 3'd6, 1'b0}, // R11 read idx8
    '{4'd2,  16'h0200, 16'h0000, 16'h0000, 32'hFFFF0801, 16'h0410, 32'h0801F7FE, 16'h0000, 3'd6, 1'b1}, // R2 unhandled
    '{4'd5,  16'h0070, 16'h0000, 16'h0000, 32'hFFFF0801, 16'h0411, 32'h0801F7FE, 16'h0000, 3'd6, 1'b0}, // R5 write P
    '{4'd2,  16'h0040, 16'h0000, 16'h0000, 32'hFFFF0801, 16'h0412, 32'h0801F7FE, 16'hFFFF, 3'd6, 1'b0}, // R2 ld ST
    '{4'd2,  16'h0014, 16'hFFFF, 16'h0000, 32'hFFFF0801, 16'h0413, 32'h0801F7FE, 16'hFFFF, 3'd6, 1'b0}, // R2 ld X,ST
    '{4'd5,  16'h0027, 16'hFFFF, 16'h0000, 32'hFFFF0801, 16'h0414, 32'h00000000, 16'hFFFF, 3'd6, 1'b0}  // R5 refresh P
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // called at a negedge with op_ready high; returns at the next negedge
  task automatic exec(input logic [15:0] op);
    op_valid = 1'b1; op_data = op;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 pc", 32'(pc_q), 32'h0400);
    chk("R1 lvl", 32'(stk_lvl), 32'd6);
    chk("R1 regs", {x_q, y_q} | acc_q | prod_q | 32'(st_q), 32'h0);
    chk("R1 flags", {30'd0, anomaly, op_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      exec(TBL[i].op);
      chk($sformatf("row %0d R%0d x", i, TBL[i].req), 32'(x_q), 32'(TBL[i].x));
      chk($sformatf("row %0d R%0d y", i, TBL[i].req), 32'(y_q), 32'(TBL[i].y));
      chk($sformatf("row %0d R%0d acc", i, TBL[i].req), acc_q, TBL[i].acc);
      chk($sformatf("row %0d R%0d pc", i, TBL[i].req), 32'(pc_q), 32'(TBL[i].pc));
      chk($sformatf("row %0d R%0d p", i, TBL[i].req), prod_q, TBL[i].p);
      chk($sformatf("row %0d R%0d st", i, TBL[i].req), 32'(st_q), 32'(TBL[i].st));
      chk($sformatf("row %0d R%0d lvl", i, TBL[i].req), 32'(stk_lvl), 32'(TBL[i].lvl));
      chk($sformatf("row %0d R%0d anomaly", i, TBL[i].req), 32'(anomaly), 32'(TBL[i].an));
    end

    // R12: idle cycles change nothing
    op_data = 16'h0015;
    repeat (2) @(negedge clk);
    chk("R12 idle pc", 32'(pc_q), 32'h0414);
    chk("R12 idle x", 32'(x_q), 32'hFFFF);

    // R8/R9: fill the stack, then overflow
    for (int k = 0; k < 6; k++) exec(16'h0050);
    chk("R8 full lvl", 32'(stk_lvl), 32'd0);
    exec(16'h0050);
    chk("R9 overflow flag", 32'(anomaly), 32'd1);
    chk("R9 overflow lvl", 32'(stk_lvl), 32'd0);
    exec(16'h0025);
    chk("R8 pop value", 32'(y_q), 32'hFFFF);
    chk("R8 pop lvl", 32'(stk_lvl), 32'd1);
    chk("R2 flag one cycle", 32'(anomaly), 32'd0);

    // R10: PC write, one-cycle stall, held opcode taken afterwards
    exec(16'h0060);
    chk("R10 pc loaded", 32'(pc_q), 32'hFFFF);
    chk("R10 ready low", 32'(op_ready), 32'd0);
    op_valid = 1'b1; op_data = 16'h00F6;
    @(negedge clk);
    chk("R10 stall no take", acc_q, 32'hFFFF0801);
    chk("R10 ready back", 32'(op_ready), 32'd1);
    @(negedge clk);
    op_valid = 1'b0;
    chk("R7 AL from PC", acc_q, 32'hFFFFFFFF);
    chk("R10 pc wrap", 32'(pc_q), 32'h0000);

    // R11/R7: high read index gives zero into upper half only
    exec(16'h0039);
    chk("R11 zero read", acc_q, 32'h0000FFFF);

    finish_run();
  end
endmodule